// File: doc/BRIEF.md
# Timed-Access Write Guard

This block protects a critical control register from stray CPU writes. Software must first write a two-byte key to a dedicated key register. Only then does the block open a short write-enable window, and only while that window is open is a write to the protected register passed through. All other writes to the protected register are dropped without any notice.

The key is the value AAh followed by the value 55h, both written to the key address. The second byte must arrive before a limited number of machine cycles have gone by since the first. Once the window opens, it stays open for a fixed number of machine cycles and then closes by itself. Machine cycles are counted on a one-clock `mc_tick` strobe and not on raw clocks, so both the arming time and the window length follow the machine-cycle rate.

The guard has three named states. IDLE is the reset state. ARMED means the first key byte has been seen. OPEN means the window is open. It has these transitions:
- IDLE→ARMED on *first_key*.
- ARMED→OPEN on *second_key*.
- ARMED→ARMED on *rearm* (AAh again, which restarts the count).
- ARMED→IDLE on *abort* (any other key value) or on *arm_timeout* (the tick limit is reached).
- OPEN→IDLE on *window_expire*.
- OPEN→ARMED on *reopen* (AAh written while the window is open).

A small demonstration register stands in for the protected bits.

Top module: `ta_guard`

## Requirements
- R1: A write to the protected address (PROT_ADDR, default B1h) changes `prot_q` at the next clock edge only while `win_open` is 1. Otherwise `prot_q` keeps its value.
- R2: Writing AAh and then 55h to the key address (KEY_ADDR, default C7h) sets `win_open` to 1 from the clock edge that samples the 55h write.
- R3: After the AAh write, the 55h write is accepted only while fewer than ARM_CYCLES (default 3) `mc_tick` pulses have been sampled. When that many ticks have been sampled, the guard returns to IDLE and a later 55h write does not open the window.
- R4: The window stays open until OPEN_CYCLES (default 3) `mc_tick` pulses have been sampled in OPEN. `win_open` drops at the edge that samples the last of those ticks. Clock cycles without a tick do not shorten the window.
- R5: While ARMED, a key write of any value other than AAh or 55h aborts to IDLE. A key write of AAh restarts the arming count from zero.
- R6: A 55h key write that is not preceded by an AAh key write has no effect, and `win_open` stays 0.
- R7: After the window closes, protected writes are dropped again until a new AAh/55h pair is written.
- R8: Reading the key address returns 0 on `rd_data`. Key writes never change `prot_q`. Reading PROT_ADDR returns `prot_q`.
- R9: After reset, `win_open` is 0, `prot_we` is 0 and `prot_q` equals PROT_INIT (default 00h).
- R10: An AAh key write while the window is open closes it at once and re-arms. A following 55h reopens the window with a full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_tick | input | 1 | One-clock machine-cycle strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address (combinational read) |
| rd_data | output | DATA_W | Read data |
| win_open | output | 1 | Write window is open |
| prot_we | output | 1 | Gated write enable for the protected register |
| prot_q | output | DATA_W | Protected demonstration register |

## Verification
The bench builds the guard with its default limits of three machine cycles for arming and three for the window. With limits this small it can sweep every tick gap from zero to five between the two key bytes, and every number of ticks from zero to four inside an open window. Each sweep point lands on one side or the other of each boundary, and the bench computes from the limit alone whether a protected write should land. The abort, re-arm, reopen, tick-free hold and read-back cases also fit within a few cycles each.

// File: rtl/ta_guard_pkg.sv
package ta_guard_pkg;

    typedef enum logic [1:0] {
        TA_IDLE  = 2'd0,
        TA_ARMED = 2'd1,
        TA_OPEN  = 2'd2
    } ta_state_e;

    typedef struct packed {
        logic first_key;
        logic second_key;
        logic other_key;
        logic prot_hit;
    } ta_evt_s;

endpackage

// File: rtl/ta_bus_decode.sv
module ta_bus_decode
    import ta_guard_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hC7,
    parameter logic [ADDR_W-1:0] PROT_ADDR  = 8'hB1,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ta_evt_s           evt
);

    logic key_sel;
    logic prot_sel;

    always_comb begin
        key_sel  = wr_en && (wr_addr == KEY_ADDR);
        prot_sel = wr_en && (wr_addr == PROT_ADDR);

        evt.first_key  = key_sel && (wr_data == KEY_FIRST);
        evt.second_key = key_sel && (wr_data == KEY_SECOND);
        evt.other_key  = key_sel && (wr_data != KEY_FIRST) && (wr_data != KEY_SECOND);
        evt.prot_hit   = prot_sel;
    end

endmodule

// File: rtl/ta_key_fsm.sv
module ta_key_fsm
    import ta_guard_pkg::*;
#(
    parameter int ARM_CYCLES  = 3,
    parameter int OPEN_CYCLES = 3
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    mc_tick,
    input  ta_evt_s evt,
    output logic    win_open,
    output logic    prot_we
);

    localparam int CNT_MAX = (ARM_CYCLES > OPEN_CYCLES) ? ARM_CYCLES : OPEN_CYCLES;
    localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);
    localparam logic [CNT_W-1:0] ARM_LAST  = CNT_W'(ARM_CYCLES - 1);
    localparam logic [CNT_W-1:0] OPEN_LAST = CNT_W'(OPEN_CYCLES - 1);

    ta_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TA_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TA_IDLE: begin
                if (evt.first_key) begin           // first_key
                    state_d = TA_ARMED;
                    cnt_d   = '0;
                end
            end
            TA_ARMED: begin
                if (evt.second_key) begin          // second_key
                    state_d = TA_OPEN;
                    cnt_d   = '0;
                end else if (evt.first_key) begin  // rearm
                    cnt_d   = '0;
                end else if (evt.other_key) begin  // abort
                    state_d = TA_IDLE;
                    cnt_d   = '0;
                end else if (mc_tick) begin
                    if (cnt_q == ARM_LAST) begin   // arm_timeout
                        state_d = TA_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            TA_OPEN: begin
                if (evt.first_key) begin           // reopen
                    state_d = TA_ARMED;
                    cnt_d   = '0;
                end else if (mc_tick) begin
                    if (cnt_q == OPEN_LAST) begin  // window_expire
                        state_d = TA_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = TA_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        win_open = (state_q == TA_OPEN);
        prot_we  = evt.prot_hit && (state_q == TA_OPEN);
    end

endmodule

// File: rtl/ta_prot_reg.sv
module ta_prot_reg #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] PROT_ADDR = 8'hB1,
    parameter logic [DATA_W-1:0] PROT_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n)  q <= PROT_INIT;
        else if (we) q <= wdata;
    end

    // key address and all others read as zero
    always_comb begin
        rd_data = (rd_addr == PROT_ADDR) ? q : '0;
    end

endmodule

// File: rtl/ta_guard.sv
module ta_guard
    import ta_guard_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR    = 8'hC7,
    parameter logic [ADDR_W-1:0] PROT_ADDR   = 8'hB1,
    parameter logic [DATA_W-1:0] KEY_FIRST   = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_SECOND  = 8'h55,
    parameter logic [DATA_W-1:0] PROT_INIT   = 8'h00,
    parameter int                ARM_CYCLES  = 3,
    parameter int                OPEN_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              win_open,
    output logic              prot_we,
    output logic [DATA_W-1:0] prot_q
);

    ta_evt_s evt;

    ta_bus_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
        .PROT_ADDR(PROT_ADDR), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .evt(evt)
    );

    ta_key_fsm #(
        .ARM_CYCLES(ARM_CYCLES), .OPEN_CYCLES(OPEN_CYCLES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .evt(evt),
        .win_open(win_open), .prot_we(prot_we)
    );

    ta_prot_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_ADDR(PROT_ADDR), .PROT_INIT(PROT_INIT)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .we(prot_we), .wdata(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .q(prot_q)
    );

endmodule

// File: rtl/ta_guard_chk.sv
module ta_guard_chk #(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR   = 8'hC7,
    parameter logic [ADDR_W-1:0] PROT_ADDR  = 8'hB1,
    parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mc_tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              win_open,
    input logic              prot_we,
    input logic [DATA_W-1:0] prot_q
);

    assert_closed_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == PROT_ADDR && !win_open) |=> $stable(prot_q));

    assert_we_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        prot_we |-> win_open);

    assert_open_needs_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> $past(wr_en && wr_addr == KEY_ADDR && wr_data == KEY_SECOND));

    assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && !mc_tick && !(wr_en && wr_addr == KEY_ADDR && wr_data == KEY_FIRST))
        |=> win_open);

    assert_key_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == KEY_ADDR) |-> (rd_data == '0));

    assert_reg_only_on_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_we |=> $stable(prot_q));

endmodule

bind ta_guard ta_guard_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
    .PROT_ADDR(PROT_ADDR), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .win_open(win_open), .prot_we(prot_we), .prot_q(prot_q)
);

// File: tb/sim_ta_guard.sv
module sim_ta_guard;

    localparam logic [7:0] KEY  = 8'hC7;
    localparam logic [7:0] PROT = 8'hB1;
    localparam logic [7:0] K1   = 8'hAA;
    localparam logic [7:0] K2   = 8'h55;
    localparam int         ARM  = 3;
    localparam int         OPN  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       win_open;
    logic       prot_we;
    logic [7:0] prot_q;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q = 8'h00;
    bit done = 0;

    always #5 clk = ~clk;

    ta_guard u0 (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .win_open(win_open), .prot_we(prot_we), .prot_q(prot_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock cycle; called and returns at a falling edge
    task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d, input logic tk);
        wr_en = we; wr_addr = a; wr_data = d; mc_tick = tk;
        @(negedge clk);
        wr_en = 1'b0; mc_tick = 1'b0;
    endtask

    task automatic unlock();
        step(1'b1, KEY, K1, 1'b0);
        step(1'b1, KEY, K2, 1'b0);
    endtask

    task automatic drain();
        for (int i = 0; i <= OPN; i++) step(1'b0, 8'h00, 8'h00, 1'b1);
    endtask

    task automatic try_prot(input string req, input logic [7:0] v, input bit open);
        step(1'b1, PROT, v, 1'b0);
        if (open) exp_q = v;
        chk(req, prot_q, exp_q);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 win_open", win_open, 0);
        chk("R9 prot_we", prot_we, 0);
        chk("R9 prot_q", prot_q, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 closed-window write dropped
        try_prot("R1 closed drop", 8'h11, 0);

        // R6 lone 55h
        step(1'b1, KEY, K2, 1'b0);
        chk("R6 lone second key", win_open, 0);
        try_prot("R6 lone second key write", 8'h12, 0);

        // R2/R3 sweep over tick gap between key bytes
        for (int g = 0; g <= 5; g++) begin
            step(1'b1, KEY, K1, 1'b0);
            for (int t = 0; t < g; t++) step(1'b0, 8'h00, 8'h00, 1'b1);
            step(1'b1, KEY, K2, 1'b0);
            chk("R2 R3 gap open", win_open, (g < ARM) ? 1 : 0);
            try_prot("R3 gap write", 8'h20 + 8'(g), g < ARM);
            drain();
        end

        // R4/R7 sweep over ticks inside the window
        for (int n = 0; n <= 4; n++) begin
            unlock();
            for (int t = 0; t < n; t++) step(1'b0, 8'h00, 8'h00, 1'b1);
            chk("R4 window state", win_open, (n < OPN) ? 1 : 0);
            try_prot("R4 R7 window write", 8'h40 + 8'(n), n < OPN);
            drain();
        end

        // R4 no ticks: window holds
        unlock();
        for (int i = 0; i < 12; i++) step(1'b0, 8'h00, 8'h00, 1'b0);
        chk("R4 hold without tick", win_open, 1);
        drain();
        chk("R7 closed after drain", win_open, 0);
        step(1'b1, KEY, K2, 1'b0);
        chk("R7 second key alone after close", win_open, 0);

        // R5 abort and rearm
        step(1'b1, KEY, K1, 1'b0);
        step(1'b1, KEY, 8'h12, 1'b0);
        step(1'b1, KEY, K2, 1'b0);
        chk("R5 abort", win_open, 0);
        step(1'b1, KEY, K1, 1'b0);
        step(1'b0, 8'h00, 8'h00, 1'b1);
        step(1'b0, 8'h00, 8'h00, 1'b1);
        step(1'b1, KEY, K1, 1'b0);
        step(1'b0, 8'h00, 8'h00, 1'b1);
        step(1'b0, 8'h00, 8'h00, 1'b1);
        step(1'b1, KEY, K2, 1'b0);
        chk("R5 rearm restarts count", win_open, 1);
        drain();

        // R10 AAh inside the window
        unlock();
        step(1'b0, 8'h00, 8'h00, 1'b1);
        step(1'b1, KEY, K1, 1'b0);
        chk("R10 reopen closes", win_open, 0);
        try_prot("R10 write while rearmed", 8'h66, 0);
        step(1'b1, KEY, K2, 1'b0);
        step(1'b0, 8'h00, 8'h00, 1'b1);
        step(1'b0, 8'h00, 8'h00, 1'b1);
        chk("R10 full length after reopen", win_open, 1);
        try_prot("R10 write after reopen", 8'h77, 1);
        drain();

        // R8 key reads and key writes vs prot_q
        unlock();
        try_prot("R8 setup write", 8'h9C, 1);
        step(1'b1, KEY, 8'h3C, 1'b0);
        step(1'b1, KEY, K1, 1'b0);
        chk("R8 key write keeps prot_q", prot_q, exp_q);
        rd_addr = KEY; #1;
        chk("R8 key reads zero", rd_data, 8'h00);
        rd_addr = PROT; #1;
        chk("R8 prot readback", rd_data, exp_q);
        drain();
        try_prot("R1 other address untouched", 8'h01, 0);
        step(1'b1, 8'h10, 8'hEE, 1'b0);
        chk("R1 unrelated write", prot_q, exp_q);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule